// File: doc/BRIEF.md
# PWM Timer Slice with Dual DAC Trigger Generator

This block is one timer slice of a PWM generator. A free-running up-counter with a programmable period drives a single PWM output, which set-compare and clear-compare events raise and drop. The slice also produces two one-clock strobes for an external DAC. The restart strobe tells the DAC to begin a new ramp. The step strobe asks the DAC to move its value by one increment.

Two selects choose the timer event behind each strobe. The restart strobe follows either the counter wrap or the output set event. The step strobe follows either a self-advancing interval comparator or the output clear event. The interval comparator moves its active match point forward by the programmed interval after every hit, so it can fire several times within one PWM period. Software uses these selects for edge-aligned slope compensation, centre-aligned slope compensation, and two-strobes-per-period hysteretic control.

The dual-strobe mode flag is taken from its request input only while the timer is stopped. A change of the request during a run has no effect until the next stop.

Top module: `pwm_dac_trig`

## Requirements
- R1: During and right after synchronous reset, `pwm_o`, `dac_rst_trig_o` and `dac_step_trig_o` are all low.
- R2: While `run_i` is high, the counter steps 0, 1, ..., `period_i` and then wraps to 0. One cycle after the counter equals `set_cmp_i`, `pwm_o` is high. One cycle after it equals `clr_cmp_i` (and not `set_cmp_i`), `pwm_o` is low. While stopped, the counter is held at 0 and `pwm_o` is low.
- R3: The mode flag copies `dual_en_i` only while `run_i` is low. A change of `dual_en_i` while running leaves both strobes unchanged until the timer has stopped.
- R4: With the mode flag clear, neither strobe is ever asserted, whatever the selects are. `pwm_o` keeps working.
- R5: With `rst_sel_i` = 0, `dac_rst_trig_o` pulses in the cycle after the counter holds `period_i`, which is the wrap cycle.
- R6: With `rst_sel_i` = 1, `dac_rst_trig_o` pulses in the cycle after the counter equals `set_cmp_i`.
- R7: With `step_sel_i` = 0, `dac_step_trig_o` pulses in the cycle after each interval match. The match points are I, 2I, 3I, ... up to `period_i`, where I = `step_ivl_i`. They restart at I after every wrap, and there are none beyond `period_i`. With I = 0 there is one match per period, at count 0.
- R8: With `step_sel_i` = 1, `dac_step_trig_o` pulses in the cycle after the counter equals `clr_cmp_i`.
- R9: A new `step_ivl_i` written while running does not move a match point that is already armed. It sets the distance to every later match, and it is the restart point after the next wrap.
- R10: With both selects at 1, the two strobes together assert exactly twice per PWM period, one on each output edge.
- R11: For `period_i` > 0, `dac_rst_trig_o` is a single-cycle pulse and is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Counter runs while high; counter held at 0 while low |
| dual_en_i | input | 1 | Dual-strobe mode request, sampled only while stopped |
| rst_sel_i | input | 1 | Restart strobe source: 0 = wrap, 1 = output set |
| step_sel_i | input | 1 | Step strobe source: 0 = interval match, 1 = output clear |
| period_i | input | CNT_W | Highest counter value before wrap |
| set_cmp_i | input | CNT_W | Counter value that sets the PWM output |
| clr_cmp_i | input | CNT_W | Counter value that clears the PWM output |
| step_ivl_i | input | CNT_W | Interval between step matches |
| pwm_o | output | 1 | PWM output |
| dac_rst_trig_o | output | 1 | DAC restart strobe |
| dac_step_trig_o | output | 1 | DAC step strobe |

## Verification
Every output is registered once after the counter value that causes it. The result of count c therefore appears in the cycle after the counter showed c. Once `run_i` rises, the counter holds c = (n-1) mod (period+1) in the cycle before the n-th rising edge. The bench samples on the falling edge that follows each rising edge and compares all three outputs in every cycle against expectations derived from that phase. Inputs change only on falling edges, including the mode request drop and the interval rewrite made in mid-run.

// File: rtl/pdt_pkg.sv
package pdt_pkg;

    typedef enum logic {
        RSRC_WRAP = 1'b0,
        RSRC_SET  = 1'b1
    } rst_src_e;

    typedef enum logic {
        SSRC_IVL = 1'b0,
        SSRC_CLR = 1'b1
    } step_src_e;

    typedef struct packed {
        logic wrap;
        logic set;
        logic clr;
        logic ivl;
    } evt_t;

    typedef struct packed {
        logic restart;
        logic step;
    } trig_t;

    function automatic logic pick_restart(rst_src_e src, evt_t e);
        return (src == RSRC_SET) ? e.set : e.wrap;
    endfunction

    function automatic logic pick_step(step_src_e src, evt_t e);
        return (src == SSRC_CLR) ? e.clr : e.ivl;
    endfunction

endpackage

// File: rtl/pdt_counter.sv
module pdt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] period,
    output logic [W-1:0] cnt,
    output logic         wrap
);

    localparam logic [W-1:0] ONE = W'(1);

    assign wrap = run && (cnt >= period);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + ONE;
        end
    end

    p_wrap_to_zero_r2: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt == '0));

    p_count_up_r2: assert property (@(posedge clk) disable iff (rst)
        (run && !wrap) |=> (cnt == $past(cnt) + ONE));

endmodule

// File: rtl/pdt_ivl_cmp.sv
module pdt_ivl_cmp #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         wrap,
    input  logic         adv_en,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] ivl,
    output logic         hit
);

    localparam int AW = W + 1;

    logic [AW-1:0] act;
    logic [AW-1:0] cnt_x;
    logic [AW-1:0] ivl_x;

    assign cnt_x = {1'b0, cnt};
    assign ivl_x = {1'b0, ivl};
    assign hit   = run && (cnt_x == act);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            act <= ivl_x;
        end else if (wrap) begin
            act <= ivl_x;
        end else if (hit && adv_en) begin
            act <= act + ivl_x;
        end
    end

    p_reload_on_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (act == {1'b0, $past(ivl)}));

    p_match_ahead_r9: assert property (@(posedge clk) disable iff (rst)
        (hit && adv_en && !wrap && ivl != '0) |=> (act >= {1'b0, cnt}));

endmodule

// File: rtl/pdt_out.sv
module pdt_out
    import pdt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  logic      en_req,
    input  rst_src_e  rsrc,
    input  step_src_e ssrc,
    input  evt_t      evt,
    output logic      mode_en,
    output logic      pwm,
    output trig_t     trig
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_en <= 1'b0;
        end else if (!run) begin
            mode_en <= en_req;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pwm <= 1'b0;
        end else if (evt.set) begin
            pwm <= 1'b1;
        end else if (evt.clr) begin
            pwm <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !mode_en) begin
            trig <= '0;
        end else begin
            trig.restart <= pick_restart(rsrc, evt);
            trig.step    <= pick_step(ssrc, evt);
        end
    end

    p_mode_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        run |=> (mode_en == $past(mode_en)));

    p_no_trig_when_off_r4: assert property (@(posedge clk) disable iff (rst)
        !mode_en |=> (trig == '0));

    p_pwm_rises_r2: assert property (@(posedge clk) disable iff (rst)
        evt.set |=> pwm);

endmodule

// File: rtl/pwm_dac_trig.sv
module pwm_dac_trig
    import pdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             dual_en_i,
    input  logic             rst_sel_i,
    input  logic             step_sel_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] set_cmp_i,
    input  logic [CNT_W-1:0] clr_cmp_i,
    input  logic [CNT_W-1:0] step_ivl_i,
    output logic             pwm_o,
    output logic             dac_rst_trig_o,
    output logic             dac_step_trig_o
);

    logic [CNT_W-1:0] cnt;
    logic             wrap;
    logic             ivl_hit;
    logic             mode_en;
    logic             adv_en;
    evt_t             evt;
    trig_t            trig;
    rst_src_e         rsrc;
    step_src_e        ssrc;

    assign rsrc   = rst_src_e'(rst_sel_i);
    assign ssrc   = step_src_e'(step_sel_i);
    assign adv_en = mode_en && (ssrc == SSRC_IVL);

    pdt_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .run    (run_i),
        .period (period_i),
        .cnt    (cnt),
        .wrap   (wrap)
    );

    pdt_ivl_cmp #(.W(CNT_W)) u_ivl (
        .clk    (clk),
        .rst    (rst),
        .run    (run_i),
        .wrap   (wrap),
        .adv_en (adv_en),
        .cnt    (cnt),
        .ivl    (step_ivl_i),
        .hit    (ivl_hit)
    );

    always_comb begin
        evt.wrap = wrap;
        evt.set  = run_i && (cnt == set_cmp_i);
        evt.clr  = run_i && (cnt == clr_cmp_i);
        evt.ivl  = ivl_hit;
    end

    pdt_out u_out (
        .clk     (clk),
        .rst     (rst),
        .run     (run_i),
        .en_req  (dual_en_i),
        .rsrc    (rsrc),
        .ssrc    (ssrc),
        .evt     (evt),
        .mode_en (mode_en),
        .pwm     (pwm_o),
        .trig    (trig)
    );

    assign dac_rst_trig_o  = trig.restart;
    assign dac_step_trig_o = trig.step;

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!pwm_o && !dac_rst_trig_o && !dac_step_trig_o));

    p_restart_single_r11: assert property (@(posedge clk) disable iff (rst)
        (dac_rst_trig_o && period_i != '0 && $stable(period_i) &&
         $stable(rst_sel_i) && $stable(set_cmp_i)) |=> !dac_rst_trig_o);

endmodule

// File: tb/pwm_dac_trig_test.sv
module pwm_dac_trig_test;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         run_i = 1'b0;
    logic         dual_en_i = 1'b0;
    logic         rst_sel_i = 1'b0;
    logic         step_sel_i = 1'b0;
    logic [W-1:0] period_i = '0;
    logic [W-1:0] set_cmp_i = '0;
    logic [W-1:0] clr_cmp_i = '0;
    logic [W-1:0] step_ivl_i = '0;
    logic         pwm_o;
    logic         dac_rst_trig_o;
    logic         dac_step_trig_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int P, S, C, IV;
    bit EN, RS, SS;
    int tot_r, tot_s;

    pwm_dac_trig #(.CNT_W(W)) uut (
        .clk             (clk),
        .rst             (rst),
        .run_i           (run_i),
        .dual_en_i       (dual_en_i),
        .rst_sel_i       (rst_sel_i),
        .step_sel_i      (step_sel_i),
        .period_i        (period_i),
        .set_cmp_i       (set_cmp_i),
        .clr_cmp_i       (clr_cmp_i),
        .step_ivl_i      (step_ivl_i),
        .pwm_o           (pwm_o),
        .dac_rst_trig_o  (dac_rst_trig_o),
        .dac_step_trig_o (dac_step_trig_o)
    );

    always #2 clk = ~clk;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic setup(int p, int s, int c, int iv, bit en, bit rs, bit ss);
        @(negedge clk);
        run_i = 1'b0;
        P = p; S = s; C = c; IV = iv; EN = en; RS = rs; SS = ss;
        period_i = W'(p); set_cmp_i = W'(s); clr_cmp_i = W'(c);
        step_ivl_i = W'(iv); dual_en_i = en; rst_sel_i = rs; step_sel_i = ss;
        repeat (2) @(negedge clk);
    endtask

    // Runs N cycles; output of count c is expected after the rising edge that follows it.
    task automatic run_check(int N, int drop_at, int chg_at, int chg_val, bit chg_mode,
                             string rq_r, string rq_s);
        bit pe = 1'b0;
        bit prv = 1'b0;
        int nr = 0;
        int ns = 0;
        run_i = 1'b1;
        for (int n = 1; n <= N; n++) begin
            int c, per;
            bit er, es;
            @(negedge clk);
            c = (n - 1) % (P + 1);
            per = (n - 1) / (P + 1);
            if (c == S) pe = 1'b1;
            else if (c == C) pe = 1'b0;
            er = EN && (RS ? (c == S) : (c == P));
            if (!EN) es = 1'b0;
            else if (SS) es = (c == C);
            else if (chg_mode) es = (per == 0) ? (c == 3 || c == 6 || c == 8)
                                               : (c >= 2 && c % 2 == 0);
            else if (IV == 0) es = (c == 0);
            else es = (c >= IV) && (c % IV == 0);
            chk(pwm_o == pe, "R2", "pwm_o", int'(pwm_o), int'(pe));
            chk(dac_rst_trig_o == er, rq_r, "dac_rst_trig_o", int'(dac_rst_trig_o), int'(er));
            chk(dac_step_trig_o == es, rq_s, "dac_step_trig_o", int'(dac_step_trig_o), int'(es));
            if (P > 0) chk(!(prv && dac_rst_trig_o), "R11", "restart back-to-back", 1, 0);
            prv = dac_rst_trig_o;
            nr += int'(dac_rst_trig_o);
            ns += int'(dac_step_trig_o);
            if (n == drop_at) dual_en_i = 1'b0;
            if (n == chg_at) step_ivl_i = W'(chg_val);
        end
        run_i = 1'b0;
        tot_r = nr;
        tot_s = ns;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(!pwm_o, "R1", "pwm_o in reset", int'(pwm_o), 0);
        chk(!dac_rst_trig_o && !dac_step_trig_o, "R1", "strobes in reset",
            int'(dac_rst_trig_o) + int'(dac_step_trig_o), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!pwm_o && !dac_rst_trig_o && !dac_step_trig_o, "R1", "outputs after reset",
            int'(pwm_o) + int'(dac_rst_trig_o) + int'(dac_step_trig_o), 0);
    endtask

    task automatic t_edge_slope();
        setup(9, 2, 7, 3, 1'b1, 1'b0, 1'b0);
        run_check(30, 0, 0, 0, 1'b0, "R5", "R7");
        chk(tot_s == 9, "R7", "step count over 3 periods", tot_s, 9);
        chk(tot_r == 3, "R5", "restart count over 3 periods", tot_r, 3);
    endtask

    task automatic t_center_slope();
        setup(9, 2, 7, 4, 1'b1, 1'b1, 1'b0);
        run_check(30, 0, 0, 0, 1'b0, "R6", "R7");
        chk(tot_r == 3, "R6", "restart count", tot_r, 3);
    endtask

    task automatic t_hysteretic();
        setup(9, 2, 7, 3, 1'b1, 1'b1, 1'b1);
        run_check(30, 0, 0, 0, 1'b0, "R10", "R8");
        chk(tot_r + tot_s == 6, "R10", "strobes over 3 periods", tot_r + tot_s, 6);
    endtask

    task automatic t_disabled();
        setup(9, 2, 7, 3, 1'b0, 1'b1, 1'b0);
        run_check(20, 0, 0, 0, 1'b0, "R4", "R4");
        chk(tot_r + tot_s == 0, "R4", "strobes while disabled", tot_r + tot_s, 0);
    endtask

    task automatic t_enable_frozen();
        setup(9, 2, 7, 3, 1'b1, 1'b0, 1'b0);
        run_check(30, 5, 0, 0, 1'b0, "R3", "R3");
        chk(tot_r == 3, "R3", "restarts after mid-run drop", tot_r, 3);
        setup(9, 2, 7, 3, 1'b0, 1'b0, 1'b0);
        run_check(20, 0, 0, 0, 1'b0, "R3", "R3");
        chk(tot_r + tot_s == 0, "R3", "strobes after stop with request low", tot_r + tot_s, 0);
    endtask

    task automatic t_ivl_change();
        setup(9, 2, 7, 3, 1'b1, 1'b0, 1'b0);
        run_check(30, 0, 5, 2, 1'b1, "R5", "R9");
        chk(tot_s == 11, "R9", "steps with interval rewrite", tot_s, 11);
    endtask

    task automatic t_ivl_edges();
        setup(9, 2, 7, 12, 1'b1, 1'b0, 1'b0);
        run_check(20, 0, 0, 0, 1'b0, "R5", "R7");
        chk(tot_s == 0, "R7", "steps with interval beyond period", tot_s, 0);
        setup(9, 2, 7, 0, 1'b1, 1'b0, 1'b0);
        run_check(20, 0, 0, 0, 1'b0, "R5", "R7");
        chk(tot_s == 2, "R7", "steps with zero interval", tot_s, 2);
    endtask

    initial begin
        t_reset();
        t_edge_slope();
        t_center_slope();
        t_hysteretic();
        t_disabled();
        t_enable_frozen();
        t_ivl_change();
        t_ivl_edges();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule